// File: doc/BRIEF.md
# Overheat Threshold Monitor with Hysteresis

This block watches a stream of signed 10-bit temperature samples and raises an overheat event when a sample reaches a programmed trip point. The trip point is surrounded by a hysteresis window chosen by a 2-bit code, and the window's half-width doubles with each code step. A sample converts to temperature as millidegrees = 423 × sample + 150000, so one LSB is 0.423 °C and a larger sample means a hotter die. The block holds the half-widths as rounded sample-unit offsets.

An event sets a latched cause bit and disarms the monitor. The cause bit drives the interrupt line through three gates: a trip enable in the control register, a local mask bit and a top-level gate bit. Software clears the cause by reading it. The monitor re-arms only after a valid sample falls strictly below the low watermark. If software reads the cause while the die is still hot, later hot samples raise nothing until the temperature has cooled below the low watermark. Software should therefore poll the temperature until it is below the low watermark and only then read the cause.

The register port uses a 3-bit address. A read returns data one cycle after the read strobe. The block has no sensor-channel logic of its own: the interrupt follows whichever channel the surrounding logic last routed into the sample port.

Top module: `ohm_monitor`

## Requirements
- R1: The high watermark is threshold + offset and the low watermark is threshold − offset. The offset for hysteresis codes 0, 1, 2 and 3 is 5, 9, 18 and 36 LSB, which is round(0.4761 × 2^(code+2) / 0.423). Both watermarks are signed values that saturate to the range −512..511. STATUS (address 4) shows the high watermark in bits [9:0] and the low watermark in bits [19:10].
- R2: While the monitor is armed, the cause bit sets on a valid sample that is at or above the high watermark, compared as signed two's complement. A sample without its valid strobe has no effect.
- R3: Setting the cause disarms the monitor, and while it is disarmed hot samples raise no new cause. A valid sample strictly below the low watermark re-arms it. The armed flag is STATUS bit 20, and it is 1 after reset.
- R4: Reading CAUSE (address 3, bit 0) returns the value held before the read and clears the cause. If a new event is detected in the same cycle as the read, the event wins and the cause stays set.
- R5: The interrupt output is high exactly when the cause is set and CTRL bit 12 (trip enable), MASK bit 0 (address 1) and GATE bit 0 (address 2) are all 1.
- R6: Register map and reset values: CTRL (address 0) holds the threshold in bits [9:0], reset 511, the hysteresis code in bits [11:10], reset 0, and the trip enable in bit 12, reset 0. MASK and GATE reset to 0. Read data appears one cycle after the read strobe, and unused bits and addresses read 0. Writes to CAUSE and STATUS are ignored.
- R7: If the cause is read back while the temperature has not yet fallen below the low watermark, later hot samples raise no interrupt until a sample re-arms the monitor.
- R8: When saturation pins the low watermark at −512, no sample can re-arm the monitor once it is disarmed. When saturation pins the high watermark at 511, a sample of 511 still trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_i | input | 10 | Signed temperature sample |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid one cycle after the read strobe |
| irq_o | output | 1 | Gated overheat interrupt |

## Verification
Assertions check on every cycle that the cause rises only from a valid armed sample at or above the high watermark, that the monitor is disarmed whenever the cause has just risen, that re-arming needs a valid sample below the low watermark, that the cause falls only on a read, and that the low watermark never exceeds the threshold, which in turn never exceeds the high watermark. Only the bench scenarios can show the exact offset for each code and the saturated watermarks at the range limits. The same holds for the full truth table of the three interrupt gates, the register map and reset values, the result when a read and a new event fall in the same cycle, and the missed interrupt that follows a read-clear made while the die is still hot.

// File: rtl/ohm_pkg.sv
package ohm_pkg;

    localparam int TEMP_W      = 10;
    localparam int HYST_W      = 2;
    localparam int HYST_N      = 1 << HYST_W;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 32;
    // half-width step and sample LSB, both in units of 1e-4 degC
    localparam int HALF_BASE_U = 4761;
    localparam int LSB_U       = 4230;
    localparam int TEMP_MAX    = (1 << (TEMP_W - 1)) - 1;
    localparam int TEMP_MIN    = -(1 << (TEMP_W - 1));

    typedef logic signed [TEMP_W-1:0] temp_t;
    typedef logic [HYST_W-1:0]        hyst_t;

    typedef struct packed {
        logic  trip_en;
        hyst_t code;
        temp_t thresh;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        temp_t hi;
        temp_t lo;
    } wmark_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_MASK  = 3'd1,
        RA_GATE  = 3'd2,
        RA_CAUSE = 3'd3,
        RA_STAT  = 3'd4
    } reg_addr_e;

    localparam ctrl_t CTRL_RST = '{trip_en: 1'b0, code: '0, thresh: temp_t'(TEMP_MAX)};

    // half-width for a code, rounded to the nearest sample LSB
    function automatic int hyst_offset(input hyst_t code);
        int num;
        num = HALF_BASE_U * (4 << code);
        return (2 * num + LSB_U) / (2 * LSB_U);
    endfunction

    function automatic temp_t clamp_temp(input int v);
        if (v > TEMP_MAX)
            return temp_t'(TEMP_MAX);
        else if (v < TEMP_MIN)
            return temp_t'(TEMP_MIN);
        else
            return temp_t'(v);
    endfunction

endpackage

// File: rtl/ohm_window.sv
module ohm_window
    import ohm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  temp_t  thresh_i,
    input  hyst_t  code_i,
    output wmark_t wm_o
);

    logic [TEMP_W-1:0] off_tab [HYST_N];

    for (genvar g = 0; g < HYST_N; g++) begin : g_off
        assign off_tab[g] = TEMP_W'(hyst_offset(hyst_t'(g)));
    end

    int hi_sum;
    int lo_sum;

    always_comb begin
        hi_sum = int'($signed(thresh_i)) + int'(off_tab[code_i]);
        lo_sum = int'($signed(thresh_i)) - int'(off_tab[code_i]);
    end

    assign wm_o.hi = clamp_temp(hi_sum);
    assign wm_o.lo = clamp_temp(lo_sum);

    AST_WM_ORDER: assert property (@(posedge clk) disable iff (rst)
        ($signed(wm_o.lo) <= $signed(thresh_i)) && ($signed(thresh_i) <= $signed(wm_o.hi))); // R1

endmodule

// File: rtl/ohm_detect.sv
module ohm_detect
    import ohm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   smp_vld_i,
    input  temp_t  smp_i,
    input  wmark_t wm_i,
    input  logic   clr_i,
    output logic   cause_o,
    output logic   armed_o
);

    logic cause_q;
    logic armed_q;
    logic hot_hit;
    logic cool_hit;

    assign hot_hit  = smp_vld_i && armed_q  && ($signed(smp_i) >= $signed(wm_i.hi));
    assign cool_hit = smp_vld_i && !armed_q && ($signed(smp_i) <  $signed(wm_i.lo));

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= 1'b0;
            armed_q <= 1'b1;
        end else begin
            if (hot_hit)
                cause_q <= 1'b1;
            else if (clr_i)
                cause_q <= 1'b0;

            if (hot_hit)
                armed_q <= 1'b0;
            else if (cool_hit)
                armed_q <= 1'b1;
        end
    end

    assign cause_o = cause_q;
    assign armed_o = armed_q;

    AST_SET_WHILE_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_q) |-> ($past(armed_q) && $past(smp_vld_i)
                            && ($signed($past(smp_i)) >= $signed($past(wm_i.hi))))); // R2

    AST_DISARM_ON_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_q) |-> !armed_q); // R3

    AST_REARM_BELOW_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(armed_q) |-> ($past(smp_vld_i)
                            && ($signed($past(smp_i)) < $signed($past(wm_i.lo))))); // R3

    AST_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (rst)
        $fell(cause_q) |-> $past(clr_i)); // R4

endmodule

// File: rtl/ohm_regs.sv
module ohm_regs
    import ohm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output ctrl_t             ctrl_o,
    output logic              mask_o,
    output logic              gate_o,
    output logic              clr_o,
    input  logic              cause_i,
    input  logic              armed_i,
    input  wmark_t            wm_i
);

    ctrl_t             ctrl_q;
    logic              mask_q;
    logic              gate_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_d;
    reg_addr_e         ra;
    logic              wdata_unused;

    assign ra           = reg_addr_e'(addr_i);
    assign wdata_unused = ^wdata_i[DATA_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            mask_q <= 1'b0;
            gate_q <= 1'b0;
        end else if (wr_i) begin
            case (ra)
                RA_CTRL: ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
                RA_MASK: mask_q <= wdata_i[0];
                RA_GATE: gate_q <= wdata_i[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_d = '0;
        case (ra)
            RA_CTRL:  rd_d[CTRL_W-1:0]   = ctrl_q;
            RA_MASK:  rd_d[0]            = mask_q;
            RA_GATE:  rd_d[0]            = gate_q;
            RA_CAUSE: rd_d[0]            = cause_i;
            RA_STAT:  rd_d[2*TEMP_W:0]   = {armed_i, wm_i.lo, wm_i.hi};
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_i)
            rdata_q <= rd_d;
    end

    assign clr_o   = rd_i && (ra == RA_CAUSE);
    assign rdata_o = rdata_q;
    assign ctrl_o  = ctrl_q;
    assign mask_o  = mask_q;
    assign gate_o  = gate_q;

endmodule

// File: rtl/ohm_monitor.sv
module ohm_monitor
    import ohm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld_i,
    input  logic [TEMP_W-1:0] smp_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    ctrl_t  ctrl;
    wmark_t wm;
    logic   mask_en;
    logic   gate_en;
    logic   clr;
    logic   cause;
    logic   armed;

    ohm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .rd_i    (reg_rd_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .ctrl_o  (ctrl),
        .mask_o  (mask_en),
        .gate_o  (gate_en),
        .clr_o   (clr),
        .cause_i (cause),
        .armed_i (armed),
        .wm_i    (wm)
    );

    ohm_window u_window (
        .clk      (clk),
        .rst      (rst),
        .thresh_i (ctrl.thresh),
        .code_i   (ctrl.code),
        .wm_o     (wm)
    );

    ohm_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .smp_vld_i (smp_vld_i),
        .smp_i     (temp_t'(smp_i)),
        .wm_i      (wm),
        .clr_i     (clr),
        .cause_o   (cause),
        .armed_o   (armed)
    );

    assign irq_o = cause && ctrl.trip_en && mask_en && gate_en;

endmodule

// File: tb/ohm_monitor_tb.sv
module ohm_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_vld = 1'b0;
    logic [9:0]  smp = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ohm_monitor dut_i (
        .clk         (clk),
        .rst         (rst),
        .smp_vld_i   (smp_vld),
        .smp_i       (smp),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic sample(input int v);
        @(negedge clk);
        smp_vld = 1'b1; smp = 10'(v);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic set_ctrl(input int th, input int code, input int en);
        wr(0, (en << 12) | (code << 10) | (th & 1023));
    endtask

    function automatic int clampv(input int v);
        if (v > 511) return 511;
        if (v < -512) return -512;
        return v;
    endfunction

    function automatic int exp_off(input int code);
        return int'(0.4761 * (2.0 ** (code + 2)) / 0.423);
    endfunction

    function automatic int armed_of(input logic [31:0] d);
        return int'(d[20]);
    endfunction

    // bring the monitor back to armed with a clear cause
    task automatic recover();
        logic [31:0] d;
        set_ctrl(511, 0, 0);
        sample(-512);
        rd(3, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        chk("R6 irq after reset", int'(irq), 0);
        rd(0, d); chk("R6 ctrl reset", int'(d), 511);
        rd(1, d); chk("R6 mask reset", int'(d), 0);
        rd(2, d); chk("R6 gate reset", int'(d), 0);
        rd(3, d); chk("R6 cause reset", int'(d), 0);
        rd(4, d); chk("R3 status reset", int'(d), (1 << 20) | (506 << 10) | 511);
        rd(5, d); chk("R6 unused address", int'(d), 0);

        // watermark sweep over every threshold and code
        for (int th = -512; th <= 511; th++) begin
            for (int c = 0; c < 4; c++) begin
                int hv;
                int lv;
                set_ctrl(th, c, 0);
                rd(4, d);
                hv = $signed(d[9:0]);
                lv = $signed(d[19:10]);
                chk("R1 high watermark", hv, clampv(th + exp_off(c)));
                chk("R1 low watermark", lv, clampv(th - exp_off(c)));
            end
        end
        rd(0, d); chk("R6 ctrl readback", int'(d), (3 << 10) | 511);

        // trip and re-arm, th=100 code 1: hi 109, lo 91
        wr(1, 1); wr(2, 1);
        set_ctrl(100, 1, 1);
        sample(108); chk("R2 below high no trip", int'(irq), 0);
        sample(109); chk("R2 trip at high", int'(irq), 1);
        rd(4, d);    chk("R3 disarmed after trip", armed_of(d), 0);
        rd(3, d);    chk("R4 cause read value", int'(d), 1);
        chk("R4 irq cleared by read", int'(irq), 0);
        sample(120); chk("R3 no trip while disarmed", int'(irq), 0);
        rd(3, d);    chk("R3 cause stays clear", int'(d), 0);
        sample(91);  rd(4, d); chk("R3 at low stays disarmed", armed_of(d), 0);
        sample(90);  rd(4, d); chk("R3 below low re-arms", armed_of(d), 1);
        sample(109); chk("R3 re-trip after re-arm", int'(irq), 1);

        // gate truth table with the cause latched
        for (int m = 0; m < 8; m++) begin
            set_ctrl(100, 1, m & 1);
            wr(1, (m >> 1) & 1);
            wr(2, (m >> 2) & 1);
            chk("R5 interrupt gating", int'(irq), (m == 7) ? 1 : 0);
        end

        // early read-clear while hot
        rd(3, d);    chk("R7 early read returns cause", int'(d), 1);
        sample(150); chk("R7 hot sample unserved", int'(irq), 0);
        rd(3, d);    chk("R7 no new cause", int'(d), 0);
        sample(80);
        sample(115); chk("R7 trip after cooling", int'(irq), 1);

        // invalid strobe ignored
        recover();
        set_ctrl(100, 1, 1);
        @(negedge clk); smp_vld = 1'b0; smp = 10'(200);
        @(negedge clk);
        chk("R2 sample without strobe ignored", int'(irq), 0);
        rd(4, d); chk("R2 still armed", armed_of(d), 1);

        // negative range, th=-20 code 0: hi -15, lo -25
        set_ctrl(-20, 0, 1);
        sample(-16); chk("R2 signed below high", int'(irq), 0);
        sample(-15); chk("R2 signed trip", int'(irq), 1);
        rd(3, d);
        sample(-25); rd(4, d); chk("R3 signed at low", armed_of(d), 0);
        sample(-26); rd(4, d); chk("R3 signed below low", armed_of(d), 1);

        // saturated low watermark
        recover();
        set_ctrl(-500, 3, 1);
        rd(4, d); chk("R8 low saturates", $signed(d[19:10]), -512);
        sample(-464); chk("R8 trip at -464", int'(irq), 1);
        rd(3, d);
        sample(-512); rd(4, d); chk("R8 cannot re-arm", armed_of(d), 0);

        // saturated high watermark
        recover();
        set_ctrl(500, 3, 1);
        rd(4, d); chk("R8 high saturates", $signed(d[9:0]), 511);
        sample(510); chk("R8 below 511", int'(irq), 0);
        sample(511); chk("R8 trip at 511", int'(irq), 1);

        // event and read in the same cycle
        recover();
        set_ctrl(100, 1, 1);
        @(negedge clk);
        smp_vld = 1'b1; smp = 10'(109);
        reg_rd = 1'b1; reg_addr = 3'd3;
        @(negedge clk);
        smp_vld = 1'b0; reg_rd = 1'b0;
        chk("R4 same-cycle read value", int'(reg_rdata[0]), 0);
        chk("R4 event wins over clear", int'(irq), 1);

        // writes to read-only registers
        recover();
        wr(3, 1);
        rd(3, d); chk("R6 cause write ignored", int'(d), 0);
        chk("R6 irq after cause write", int'(irq), 0);
        wr(4, -1);
        rd(4, d); chk("R6 status write ignored", int'(d), (1 << 20) | (506 << 10) | 511);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule